// File: doc/BRIEF.md
# Front-End Link Transaction Responder

This block sits at the front-end end of a full-duplex readout link. It takes 32-bit words from the backward (control) channel, decodes the opening word of each transaction and carries out one of five transaction kinds. The five kinds are a plain command, a status read, a block write, a block read-back and a data-collection run. It reaches front-end registers and memory over a simple address/strobe bus. It returns replies and event data on the 32-bit forward channel.

The opening word of a transaction holds an opcode in bits [3:0] and a front-end address in bits [31:13]. In a block transfer the second word gives the length in 32-bit words. The bus address starts at the given address and steps up by one per word. While a run is active, events come in from a local event source as a stream. The first word of each event is its length, and the responder frames every event on the forward channel. The receiver can throttle the forward channel at any time with an XOFF level. A backward word that is not expected in the current state is dropped, and the error flag is raised.

Top module: `fe_link_responder`

## Requirements
- R1: While reset is asserted, fw_valid, fe_cmd, fe_wr, fe_rd, ev_ready and cmd_err are all low.
- R2: A word with opcode 1 received when idle gives a single-cycle fe_cmd pulse, with fe_addr equal to word bits [31:13]. It produces no forward word.
- R3: Opcode 2 (status read) holds fe_rd high, with fe_addr steady at the word's address field, until fe_rack arrives. The fe_rdata value captured with fe_rack is then sent as exactly one forward word.
- R4: Opcode 3 (block write) takes the next word's bits [15:0] as the length N. The next N words are written with fe_wr to addresses A, A+1, … A+N-1. After them a word with opcode 7 is expected as end of transaction. Any other word in that slot raises cmd_err and ends the transaction.
- R5: Opcode 4 (block read-back) takes a length N from the next word and reads N words from A upward. It forwards them in order, followed by the end-of-block word 0x000000B8 and the end-of-transaction word 0x000000E7.
- R6: Opcode 5 starts a run. In a run, each event taken from the event stream is forwarded as its length word (bits [15:0] give the count N), then N data words, then the end-of-event word 0x000000E5.
- R7: Opcode 6 ends a run. If it arrives during an event, that event is completed first. If it arrives when no event is in progress, the run stops at once and no event offered in the same cycle is taken. After the run ends, no event words are consumed.
- R8: fw_valid is never high in the cycle that follows a cycle with fw_xoff high. ev_ready is low whenever fw_xoff is high.
- R9: A backward word that arrives while a transaction cannot accept it raises cmd_err for one cycle and has no other effect. The same applies to an idle word with an opcode other than 1–5, and to a non-end-run word during a run.
- R10: A length of zero is legal. A block write expects the end-of-transaction word at once. A block read returns only 0x000000B8 and 0x000000E7. An event is forwarded as its length word followed by 0x000000E5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bk_valid | input | 1 | Backward channel word present |
| bk_data | input | 32 | Backward channel word |
| fw_valid | output | 1 | Forward channel word present |
| fw_data | output | 32 | Forward channel word |
| fw_xoff | input | 1 | Receiver requests the forward channel to pause |
| fe_addr | output | 19 | Front-end bus address |
| fe_cmd | output | 1 | Plain command strobe |
| fe_wr | output | 1 | Front-end write strobe |
| fe_rd | output | 1 | Front-end read request, held until acknowledged |
| fe_wdata | output | 32 | Front-end write data |
| fe_rdata | input | 32 | Front-end read data, valid with fe_rack |
| fe_rack | input | 1 | Front-end read acknowledge |
| ev_valid | input | 1 | Event stream word present |
| ev_data | input | 32 | Event stream word (length first, then data) |
| ev_ready | output | 1 | Event stream word accepted this cycle |
| cmd_err | output | 1 | One-cycle flag for a rejected backward word |

## Verification
A wrong state or length counter in this block shows up on the forward channel within one transaction. The block-read and event framing shifts, so the end-of-block, end-of-transaction and end-of-event words appear one word early or late, or never appear. A wrong address register shows as read-back data from the wrong locations. A state that accepts or refuses backward words wrongly shows as a cmd_err pulse, or a missing one, on the cycle after the word. An XOFF path that is not honoured shows as a forward word in the cycle right after XOFF.

// File: rtl/fe_link_responder.sv
module fe_link_responder #(
  parameter int ADDR_W = 19,
  parameter int LEN_W  = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bk_valid,
  input  logic [DW-1:0]     bk_data,
  output logic              fw_valid,
  output logic [DW-1:0]     fw_data,
  input  logic              fw_xoff,
  output logic [ADDR_W-1:0] fe_addr,
  output logic              fe_cmd,
  output logic              fe_wr,
  output logic              fe_rd,
  output logic [DW-1:0]     fe_wdata,
  input  logic [DW-1:0]     fe_rdata,
  input  logic              fe_rack,
  input  logic              ev_valid,
  input  logic [DW-1:0]     ev_data,
  output logic              ev_ready,
  output logic              cmd_err
);

  localparam logic [3:0] OP_CMD = 4'd1;
  localparam logic [3:0] OP_STAT = 4'd2;
  localparam logic [3:0] OP_BWR = 4'd3;
  localparam logic [3:0] OP_BRD = 4'd4;
  localparam logic [3:0] OP_RUN = 4'd5;
  localparam logic [3:0] OP_END = 4'd6;
  localparam logic [3:0] OP_EOT = 4'd7;
  localparam logic [DW-1:0] MK_EOB = DW'(32'h0000_00B8);
  localparam logic [DW-1:0] MK_EOT = DW'(32'h0000_00E7);
  localparam logic [DW-1:0] MK_EOE = DW'(32'h0000_00E5);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_STRD, S_STSEND, S_BWLEN, S_BWDAT, S_BWEOT, S_BRLEN,
    S_BRRD, S_BRSEND, S_BREOB, S_BREOT, S_RUNIDLE, S_RUNDAT, S_RUNEOE
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  cnt;
  logic [DW-1:0]     data_q;
  logic              stop_q;

  wire [3:0]        op       = bk_data[3:0];
  wire [ADDR_W-1:0] bk_addr  = bk_data[DW-1 -: ADDR_W];
  wire [LEN_W-1:0]  bk_len   = bk_data[LEN_W-1:0];
  wire [LEN_W-1:0]  ev_len   = ev_data[LEN_W-1:0];
  wire              end_now  = bk_valid && (op == OP_END);
  wire              in_run   = (st == S_RUNIDLE) || (st == S_RUNDAT) || (st == S_RUNEOE);
  wire              takes_bk = (st == S_IDLE) || (st == S_BWLEN) || (st == S_BWDAT) ||
                               (st == S_BWEOT) || (st == S_BRLEN) || in_run;
  wire              ev_take  = ev_valid && ev_ready;

  assign ev_ready = !fw_xoff && (((st == S_RUNIDLE) && !end_now) || (st == S_RUNDAT));
  assign fe_cmd   = (st == S_IDLE) && bk_valid && (op == OP_CMD);
  assign fe_wr    = (st == S_BWDAT) && bk_valid;
  assign fe_rd    = (st == S_STRD) || (st == S_BRRD);
  assign fe_wdata = bk_data;
  assign fe_addr  = fe_cmd ? bk_addr : addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      cnt      <= '0;
      data_q   <= '0;
      stop_q   <= 1'b0;
      fw_valid <= 1'b0;
      fw_data  <= '0;
      cmd_err  <= 1'b0;
    end else begin
      fw_valid <= 1'b0;
      cmd_err  <= bk_valid && !takes_bk;
      if (in_run && bk_valid && op != OP_END) cmd_err <= 1'b1;
      case (st)
        S_IDLE: if (bk_valid) begin
          case (op)
            OP_CMD: ;
            OP_STAT: begin addr_q <= bk_addr; st <= S_STRD; end
            OP_BWR: begin addr_q <= bk_addr; st <= S_BWLEN; end
            OP_BRD: begin addr_q <= bk_addr; st <= S_BRLEN; end
            OP_RUN: begin stop_q <= 1'b0; st <= S_RUNIDLE; end
            default: cmd_err <= 1'b1;
          endcase
        end
        S_STRD: if (fe_rack) begin data_q <= fe_rdata; st <= S_STSEND; end
        S_STSEND: if (!fw_xoff) begin
          fw_valid <= 1'b1;
          fw_data  <= data_q;
          st       <= S_IDLE;
        end
        S_BWLEN: if (bk_valid) begin
          cnt <= bk_len;
          st  <= (bk_len == '0) ? S_BWEOT : S_BWDAT;
        end
        S_BWDAT: if (bk_valid) begin
          addr_q <= addr_q + 1'b1;
          cnt    <= cnt - ONE;
          if (cnt == ONE) st <= S_BWEOT;
        end
        S_BWEOT: if (bk_valid) begin
          if (op != OP_EOT) cmd_err <= 1'b1;
          st <= S_IDLE;
        end
        S_BRLEN: if (bk_valid) begin
          cnt <= bk_len;
          st  <= (bk_len == '0) ? S_BREOB : S_BRRD;
        end
        S_BRRD: if (fe_rack) begin data_q <= fe_rdata; st <= S_BRSEND; end
        S_BRSEND: if (!fw_xoff) begin
          fw_valid <= 1'b1;
          fw_data  <= data_q;
          addr_q   <= addr_q + 1'b1;
          cnt      <= cnt - ONE;
          st       <= (cnt == ONE) ? S_BREOB : S_BRRD;
        end
        S_BREOB: if (!fw_xoff) begin
          fw_valid <= 1'b1;
          fw_data  <= MK_EOB;
          st       <= S_BREOT;
        end
        S_BREOT: if (!fw_xoff) begin
          fw_valid <= 1'b1;
          fw_data  <= MK_EOT;
          st       <= S_IDLE;
        end
        S_RUNIDLE: begin
          if (end_now) st <= S_IDLE;
          else if (ev_take) begin
            fw_valid <= 1'b1;
            fw_data  <= ev_data;
            cnt      <= ev_len;
            st       <= (ev_len == '0) ? S_RUNEOE : S_RUNDAT;
          end
        end
        S_RUNDAT: begin
          if (end_now) stop_q <= 1'b1;
          if (ev_take) begin
            fw_valid <= 1'b1;
            fw_data  <= ev_data;
            cnt      <= cnt - ONE;
            if (cnt == ONE) st <= S_RUNEOE;
          end
        end
        S_RUNEOE: begin
          if (end_now) stop_q <= 1'b1;
          if (!fw_xoff) begin
            fw_valid <= 1'b1;
            fw_data  <= MK_EOE;
            st       <= (stop_q || end_now) ? S_IDLE : S_RUNIDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_xoff_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fw_xoff |=> !fw_valid);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_rd && !fe_rack) |=> (fe_rd && $stable(fe_addr)));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(bk_valid));

  assert_ev_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> fw_valid);

  assert_cmd_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fe_cmd |=> !fw_valid);

endmodule

// File: tb/fe_link_responder_tb.sv
`timescale 1ns/1ps
module fe_link_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bk_valid = 1'b0;
  logic [31:0] bk_data = '0;
  logic        fw_valid;
  logic [31:0] fw_data;
  logic        fw_xoff = 1'b0;
  logic [18:0] fe_addr;
  logic        fe_cmd, fe_wr, fe_rd;
  logic [31:0] fe_wdata, fe_rdata;
  logic        fe_rack = 1'b0;
  logic        ev_valid;
  logic [31:0] ev_data;
  logic        ev_ready;
  logic        cmd_err;

  always #10 clk = ~clk;

  fe_link_responder u_dut (
    .clk(clk), .rst_n(rst_n), .bk_valid(bk_valid), .bk_data(bk_data),
    .fw_valid(fw_valid), .fw_data(fw_data), .fw_xoff(fw_xoff),
    .fe_addr(fe_addr), .fe_cmd(fe_cmd), .fe_wr(fe_wr), .fe_rd(fe_rd),
    .fe_wdata(fe_wdata), .fe_rdata(fe_rdata), .fe_rack(fe_rack),
    .ev_valid(ev_valid), .ev_data(ev_data), .ev_ready(ev_ready),
    .cmd_err(cmd_err)
  );

  // {exp_err, exp_cmd, word}
  localparam logic [33:0] VEC [0:5] = '{
    {1'b0, 1'b1, 19'h00ABC, 9'd0, 4'h1},
    {1'b1, 1'b0, 19'h00001, 9'd0, 4'h0},
    {1'b1, 1'b0, 19'h00002, 9'd0, 4'h7},
    {1'b1, 1'b0, 19'h00003, 9'd0, 4'h6},
    {1'b1, 1'b0, 19'h00004, 9'd0, 4'hF},
    {1'b0, 1'b1, 19'h7FFFF, 9'd0, 4'h1}
  };
  localparam logic [31:0] WD [0:3] = '{32'hCAFE0001, 32'h12345678, 32'hDEADBEEF, 32'h0BADF00D};

  logic [31:0] fe_mem [0:63];
  logic [31:0] fw_log [0:127];
  logic [31:0] ev_mem [0:31];
  int fw_n = 0, err_n = 0, cmd_n = 0, wr_n = 0, xoff_bad = 0, dly = 0;
  int ev_rd = 0, ev_end = 0;
  logic [18:0] cmd_addr = '0, wr_addr = '0;
  logic prev_xoff = 1'b0;
  int total = 0, fails = 0;

  assign fe_rdata = fe_mem[fe_addr[5:0]];
  assign ev_valid = ev_rd < ev_end;
  assign ev_data  = ev_mem[ev_rd[4:0]];

  always @(posedge clk) begin
    if (fw_valid) begin fw_log[fw_n[6:0]] <= fw_data; fw_n <= fw_n + 1; end
    if (cmd_err) err_n <= err_n + 1;
    if (fe_cmd) begin cmd_n <= cmd_n + 1; cmd_addr <= fe_addr; end
    if (fe_wr) begin fe_mem[fe_addr[5:0]] <= fe_wdata; wr_n <= wr_n + 1; wr_addr <= fe_addr; end
    if (rst_n && ((prev_xoff && fw_valid) || (fw_xoff && ev_ready))) xoff_bad <= xoff_bad + 1;
    prev_xoff <= fw_xoff;
    if (ev_valid && ev_ready) ev_rd <= ev_rd + 1;
    if (fe_rd && !fe_rack) begin
      if (dly == 5) begin fe_rack <= 1'b1; dly <= 0; end
      else dly <= dly + 1;
    end else fe_rack <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    bk_valid = 1'b1; bk_data = w;
    @(negedge clk);
    bk_valid = 1'b0;
  endtask

  function automatic logic [31:0] mkw(input logic [18:0] a, input logic [3:0] op);
    return {a, 9'd0, op};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int f0, e0, c0, w0, r0;
    tick(3);
    chk("R1 fw_valid", 32'(fw_valid), 0);
    chk("R1 strobes", {29'd0, fe_cmd, fe_wr, fe_rd}, 0);
    chk("R1 ev_ready/err", {30'd0, ev_ready, cmd_err}, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 / R9 opcode table
    foreach (VEC[i]) begin
      f0 = fw_n; e0 = err_n; c0 = cmd_n;
      send(VEC[i][31:0]);
      tick(3);
      chk($sformatf("R9 err vec%0d", i), 32'(err_n - e0), 32'(VEC[i][33]));
      chk($sformatf("R2 cmd vec%0d", i), 32'(cmd_n - c0), 32'(VEC[i][32]));
      chk($sformatf("R2 no reply vec%0d", i), 32'(fw_n - f0), 0);
      if (VEC[i][32]) chk($sformatf("R2 cmd addr vec%0d", i), 32'(cmd_addr), 32'(VEC[i][31:13]));
    end

    // R4 block write 4 words at 0x10
    e0 = err_n; w0 = wr_n;
    send(mkw(19'h10, 4'h3)); send(32'd4);
    for (int k = 0; k < 4; k++) send(WD[k]);
    send(mkw(19'h0, 4'h7));
    tick(3);
    chk("R4 writes", 32'(wr_n - w0), 4);
    chk("R4 last addr", 32'(wr_addr), 32'h13);
    chk("R4 no err", 32'(err_n - e0), 0);

    // R5 block read back
    f0 = fw_n;
    send(mkw(19'h10, 4'h4)); send(32'd4);
    tick(80);
    chk("R5 count", 32'(fw_n - f0), 6);
    for (int k = 0; k < 4; k++) chk($sformatf("R5 word%0d", k), fw_log[f0 + k], WD[k]);
    chk("R5 eob", fw_log[f0 + 4], 32'h000000B8);
    chk("R5 eot", fw_log[f0 + 5], 32'h000000E7);

    // R3 status read
    f0 = fw_n;
    send(mkw(19'h12, 4'h2));
    tick(5);
    chk("R3 wait for ack", 32'(fw_n - f0), 0);
    tick(15);
    chk("R3 one word", 32'(fw_n - f0), 1);
    chk("R3 value", fw_log[f0], WD[2]);

    // R9 command while status read busy
    f0 = fw_n; e0 = err_n; c0 = cmd_n;
    send(mkw(19'h11, 4'h2));
    tick(2);
    send(mkw(19'h5, 4'h1));
    tick(20);
    chk("R9 busy err", 32'(err_n - e0), 1);
    chk("R9 busy no cmd", 32'(cmd_n - c0), 0);
    chk("R9 reply intact", fw_log[f0], WD[1]);

    // R4 bad end-of-transaction word
    e0 = err_n; c0 = cmd_n;
    send(mkw(19'h20, 4'h3)); send(32'd1); send(32'h55AA55AA);
    send(mkw(19'h6, 4'h1));
    tick(2);
    chk("R4 bad eot err", 32'(err_n - e0), 1);
    chk("R4 bad eot no cmd", 32'(cmd_n - c0), 0);
    send(mkw(19'h6, 4'h1));
    tick(2);
    chk("R4 idle after abort", 32'(cmd_n - c0), 1);

    // R10 zero lengths
    f0 = fw_n; e0 = err_n; w0 = wr_n;
    send(mkw(19'h30, 4'h4)); send(32'd0);
    tick(10);
    chk("R10 read len0 count", 32'(fw_n - f0), 2);
    chk("R10 read len0 eob", fw_log[f0], 32'h000000B8);
    chk("R10 read len0 eot", fw_log[f0 + 1], 32'h000000E7);
    send(mkw(19'h30, 4'h3)); send(32'd0); send(mkw(19'h0, 4'h7));
    tick(3);
    chk("R10 write len0", 32'(wr_n - w0), 0);
    chk("R10 write len0 err", 32'(err_n - e0), 0);

    // R6 / R8 run with XOFF stalls, second event of length 0
    ev_mem[0] = 32'd3; ev_mem[1] = 32'hA1; ev_mem[2] = 32'hA2; ev_mem[3] = 32'hA3; ev_mem[4] = 32'd0;
    ev_end = 5;
    f0 = fw_n;
    send(mkw(19'h0, 4'h5));
    tick(1);
    fw_xoff = 1'b1;
    tick(4);
    fw_xoff = 1'b0;
    tick(1);
    fw_xoff = 1'b1;
    tick(2);
    fw_xoff = 1'b0;
    tick(20);
    send(mkw(19'h0, 4'h6));
    tick(3);
    chk("R6 count", 32'(fw_n - f0), 7);
    chk("R6 len", fw_log[f0], 32'd3);
    chk("R6 d0", fw_log[f0 + 1], 32'hA1);
    chk("R6 d2", fw_log[f0 + 3], 32'hA3);
    chk("R6 eoe", fw_log[f0 + 4], 32'h000000E5);
    chk("R10 ev len0", fw_log[f0 + 5], 32'd0);
    chk("R10 ev len0 eoe", fw_log[f0 + 6], 32'h000000E5);
    chk("R8 xoff respected", 32'(xoff_bad), 0);

    // R7 end-run mid event, then pending event untouched
    ev_mem[5] = 32'd4;
    for (int k = 0; k < 4; k++) ev_mem[6 + k] = 32'hC0 + 32'(k);
    ev_mem[10] = 32'd1; ev_mem[11] = 32'hCC;
    ev_end = 12;
    f0 = fw_n;
    send(mkw(19'h0, 4'h5));
    tick(2);
    send(mkw(19'h0, 4'h6));
    tick(20);
    chk("R7 event finished", 32'(fw_n - f0), 6);
    chk("R7 last d", fw_log[f0 + 4], 32'hC3);
    chk("R7 eoe", fw_log[f0 + 5], 32'h000000E5);
    chk("R7 no further event", 32'(ev_rd), 10);

    // R7 start and end back to back: pending event not taken
    f0 = fw_n; e0 = err_n; r0 = ev_rd;
    send(mkw(19'h0, 4'h5));
    send(mkw(19'h0, 4'h6));
    tick(10);
    chk("R7 same-cycle end", 32'(ev_rd - r0), 0);
    chk("R7 no output", 32'(fw_n - f0), 0);
    chk("R7 no err", 32'(err_n - e0), 0);
    chk("R8 xoff final", 32'(xoff_bad), 0);

    finish_run();
  end
endmodule